// File: doc/BRIEF.md
# SD Card Data FIFO with Fill Thresholds

This block is the word buffer between the host register port of an SD card controller and its card-side data engine. It holds up to sixteen 32-bit words. The host moves one word per access through a data port. The card engine fills the buffer during card reads and drains it during card writes. A direction input selects which side produces words and which side consumes them. Accesses from the side that does not match the current direction have no effect.

A packed configuration word shows the live fill count and holds two 5-bit thresholds. The read threshold tells the host when enough words have arrived. The write threshold tells the host when enough space is free. A small status word carries a data-ready flag built from these thresholds. It also carries a sticky error bit, which is set when the host reads an empty buffer or writes a full one, and is cleared by writing 1 to it. Serialising words onto the card data lines happens elsewhere.

Top module: `sdx_fifo_top`

## Requirements
- R1: After reset the buffer is empty, fill_level is 0, both thresholds are 4, the error bit is 0, the direction is card-read (dir_wr = 0) and host_status is 0.
- R2: Words leave the buffer in the order they entered it, and up to 16 words can be held. The head word appears combinationally on host_rdata in read direction, or on card_rdata in write direction.
- R3: The fill count appears on fill_level and in cfg_rdata bits 8:4, one clock edge after the access that changed it, and changes by at most one per clock except on a flush.
- R4: A write to cfg_wdata loads the write threshold from bits 13:9 and the read threshold from bits 18:14. cfg_rdata returns the fill count at 8:4, the write threshold at 13:9, the read threshold at 18:14 and zero in every other bit.
- R5: In read direction, host_status bit 0 (data ready) is 1 exactly when the fill count is at least the read threshold.
- R6: In write direction, host_status bit 0 is 1 exactly when 16 minus the fill count is at least the write threshold.
- R7: In read direction, a host read of an empty buffer returns 0 on host_rdata, leaves the fill count unchanged and sets the error bit, host_status bit 3.
- R8: In write direction, a host write to a full buffer is dropped without changing the contents or the count, and it sets the error bit.
- R9: The error bit stays set until sts_wr is asserted with sts_wdata bit 3 = 1. If a new violation occurs in the same cycle as the clear, the bit stays set.
- R10: A change of dir_wr empties the buffer at the next clock edge. Any data access in that cycle is ignored.
- R11: Accesses from the side that does not match the direction have no effect. A card push into a full buffer and a card pop from an empty one are ignored and do not set the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_wr | input | 1 | Transfer direction: 1 = card write (host fills), 0 = card read (card fills) |
| host_rd | input | 1 | Host pops one word this cycle |
| host_rdata | output | 32 | Head word for the host, 0 when empty or in write direction |
| host_wr | input | 1 | Host pushes one word this cycle |
| host_wdata | input | 32 | Word pushed by the host |
| card_push | input | 1 | Card engine pushes one word this cycle |
| card_wdata | input | 32 | Word pushed by the card engine |
| card_pop | input | 1 | Card engine pops one word this cycle |
| card_rdata | output | 32 | Head word for the card engine, 0 when empty or in read direction |
| fill_level | output | 5 | Number of words held |
| cfg_wr | input | 1 | Load the thresholds from cfg_wdata |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Packed fill count and thresholds |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 4 | Status write word; bit 3 clears the error |
| host_status | output | 4 | Bit 0 data ready, bit 3 sticky error, others 0 |

## Verification
The head word on host_rdata and card_rdata depends only on the stored state, so it is due in the same cycle as the request. The bench checks it one nanosecond after driving the inputs on the falling edge. The fill count, the configuration word, the data-ready flag and the error bit all come from registers, so each is due at the first rising edge after its stimulus. The bench samples them one nanosecond after that edge against a queue model that it advanced for that cycle. A direction change is modelled as a flush that takes effect at that same edge, and accesses in that cycle are treated as ignored.

// File: rtl/sdx_fifo_pkg.sv
`timescale 1ns/1ps
package sdx_fifo_pkg;
  // packed configuration word layout
  localparam int CFG_W      = 32;
  localparam int FILL_LSB   = 4;
  // status word layout
  localparam int STS_W      = 4;
  localparam int STS_RDY    = 0;
  localparam int STS_ERR    = 3;

  // free slots left in a buffer of the given depth
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned fill);
    return depth - fill;
  endfunction

  // data-ready rule: reads compare fill, writes compare free space
  function automatic logic data_ready(input logic wdir,
                                      input int unsigned depth,
                                      input int unsigned fill,
                                      input int unsigned rd_thr,
                                      input int unsigned wr_thr);
    if (wdir) return free_slots(depth, fill) >= wr_thr;
    return fill >= rd_thr;
  endfunction
endpackage

// File: rtl/sdx_fifo_store.sv
`timescale 1ns/1ps
module sdx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= wdata;
  end

  assign head = mem[rptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R10
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == $past(count)) || (count == $past(count) + 1'b1)
               || ($past(count) == count + 1'b1)); // R3
endmodule

// File: rtl/sdx_fifo_ctrl.sv
`timescale 1ns/1ps
module sdx_fifo_ctrl #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_wr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          card_push,
  input  logic [DW-1:0] card_wdata,
  input  logic          card_pop,
  input  logic [CW-1:0] count,
  output logic          dir_q,
  output logic          flush,
  output logic          push,
  output logic          pop,
  output logic [DW-1:0] push_data,
  output logic          host_viol
);
  logic rd_dir, empty, full, push_req, pop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_wr;
  end

  assign flush     = dir_wr != dir_q;
  assign rd_dir    = !dir_q;
  assign empty     = count == '0;
  assign full      = count == CW'(DEPTH);
  assign push_req  = rd_dir ? card_push : host_wr;
  assign pop_req   = rd_dir ? host_rd   : card_pop;
  assign push_data = rd_dir ? card_wdata : host_wdata;
  assign push      = !flush && push_req && !full;
  assign pop       = !flush && pop_req && !empty;
  assign host_viol = !flush && ((rd_dir && host_rd && empty) ||
                                (!rd_dir && host_wr && full));

  AST_CARD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir && !host_rd) || (!rd_dir && !host_wr) |-> !host_viol); // R11
endmodule

// File: rtl/sdx_fifo_regs.sv
`timescale 1ns/1ps
module sdx_fifo_regs
  import sdx_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RST_THR = 4,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int WT_LSB = FILL_LSB + CW,
  localparam int RT_LSB = WT_LSB + CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic [CW-1:0]    count,
  input  logic             dir_q,
  input  logic             host_viol,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [STS_W-1:0] host_status
);
  logic [CW-1:0] rd_thr, wr_thr;
  logic          fifo_err, err_clr, rdy;
  logic          unused_bits;

  assign unused_bits = ^cfg_wdata ^ ^sts_wdata;
  assign err_clr     = sts_wr && sts_wdata[STS_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_thr <= CW'(RST_THR);
      wr_thr <= CW'(RST_THR);
    end else if (cfg_wr) begin
      wr_thr <= cfg_wdata[WT_LSB +: CW];
      rd_thr <= cfg_wdata[RT_LSB +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fifo_err <= 1'b0;
    else if (host_viol) fifo_err <= 1'b1;
    else if (err_clr)   fifo_err <= 1'b0;
  end

  assign rdy = data_ready(dir_q, DEPTH, 32'(count), 32'(rd_thr), 32'(wr_thr));

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[FILL_LSB +: CW] = count;
    cfg_rdata[WT_LSB +: CW]   = wr_thr;
    cfg_rdata[RT_LSB +: CW]   = rd_thr;
    host_status          = '0;
    host_status[STS_RDY] = rdy;
    host_status[STS_ERR] = fifo_err;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err && !err_clr |=> fifo_err); // R9
  AST_VIOL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    host_viol |=> host_status[STS_ERR]); // R7
  AST_CLR_DROPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !host_viol |=> !host_status[STS_ERR]); // R9
endmodule

// File: rtl/sdx_fifo_top.sv
`timescale 1ns/1ps
module sdx_fifo_top
  import sdx_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DW      = 32,
  parameter int RST_THR = 4,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             card_push,
  input  logic [DW-1:0]    card_wdata,
  input  logic             card_pop,
  output logic [DW-1:0]    card_rdata,
  output logic [CW-1:0]    fill_level,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic [STS_W-1:0] host_status
);
  logic          dir_q, flush, push, pop, host_viol, has_data;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] count;

  sdx_fifo_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
    .count(count), .dir_q(dir_q), .flush(flush), .push(push), .pop(pop),
    .push_data(push_data), .host_viol(host_viol));

  sdx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(push_data), .head(head), .count(count));

  sdx_fifo_regs #(.DEPTH(DEPTH), .RST_THR(RST_THR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .count(count), .dir_q(dir_q),
    .host_viol(host_viol), .cfg_rdata(cfg_rdata), .host_status(host_status));

  assign has_data   = count != '0;
  assign host_rdata = (!dir_q && has_data) ? head : '0;
  assign card_rdata = (dir_q && has_data)  ? head : '0;
  assign fill_level = count;

  AST_FILL_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[FILL_LSB +: CW] == fill_level); // R3
endmodule

// File: tb/tb_sdx_fifo_top.sv
`timescale 1ns/1ps
module tb_sdx_fifo_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        dir_wr = 0, host_rd = 0, host_wr = 0, card_push = 0, card_pop = 0;
  logic        cfg_wr = 0, sts_wr = 0;
  logic [31:0] host_wdata = 0, card_wdata = 0, cfg_wdata = 0;
  logic [3:0]  sts_wdata = 0;
  logic [31:0] host_rdata, card_rdata, cfg_rdata;
  logic [4:0]  fill_level;
  logic [3:0]  host_status;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;

  logic [31:0] q[$];
  logic        m_dir = 0, m_err = 0;
  int unsigned m_rt = 4, m_wt = 4;

  always #10 clk = ~clk;

  sdx_fifo_top dut (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .card_push(card_push), .card_wdata(card_wdata),
    .card_pop(card_pop), .card_rdata(card_rdata),
    .fill_level(fill_level), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .host_status(host_status));

  function automatic logic exp_ready(input logic wdir, input int unsigned n);
    if (wdir) return (n + m_wt) <= 16;
    return !(n < m_rt);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic dir, input logic hrd, input logic hwr,
                      input logic [31:0] hwd, input logic cps,
                      input logic [31:0] cwd, input logic cpp,
                      input logic cfw, input logic [31:0] cfd,
                      input logic stw, input logic [3:0] std);
    logic flush, rd, full, empty, set, pushq, popq;
    logic [31:0] hd;
    @(negedge clk);
    dir_wr = dir; host_rd = hrd; host_wr = hwr; host_wdata = hwd;
    card_push = cps; card_wdata = cwd; card_pop = cpp;
    cfg_wr = cfw; cfg_wdata = cfd; sts_wr = stw; sts_wdata = std;
    #1;
    hd = (q.size() > 0) ? q[0] : 32'h0;
    if (hrd && !m_dir) chk(q.size() > 0 ? "R2 host head" : "R7 empty read", host_rdata, hd);
    if (cpp && m_dir)  chk("R2 card head", card_rdata, hd);
    flush = dir != m_dir;
    set = 0;
    if (flush) begin
      q.delete();
      m_dir = dir;
    end else begin
      rd = !m_dir;
      full = q.size() == 16;
      empty = q.size() == 0;
      pushq = rd ? cps : hwr;
      popq  = rd ? hrd : cpp;
      set = rd ? (hrd && empty) : (hwr && full);
      if (popq && !empty) void'(q.pop_front());
      if (pushq && !full) q.push_back(rd ? cwd : hwd);
    end
    if (cfw) begin
      m_wt = cfd[13:9];
      m_rt = cfd[18:14];
    end
    if (set) m_err = 1;
    else if (stw && std[3]) m_err = 0;
    @(posedge clk);
    #1;
    chk("R3 fill", 32'(fill_level), q.size());
    chk("R4 cfg word", cfg_rdata, (q.size() << 4) | (m_wt << 9) | (m_rt << 14));
    chk(m_dir ? "R6 ready" : "R5 ready", 32'(host_status[0]), 32'(exp_ready(m_dir, q.size())));
    chk("R9 error bit", 32'(host_status[3]), 32'(m_err));
    chk("R1 spare bits", 32'(host_status[2:1]), 0);
  endtask

  task automatic idle(input logic dir);
    step(dir, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5d17));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 fill", 32'(fill_level), 0);
    chk("R1 cfg", cfg_rdata, (4 << 9) | (4 << 14));
    chk("R1 status", 32'(host_status), 0);
    @(negedge clk); rst_n = 1;
    idle(0);
    // R5/R11: card fills read direction past full; extra push dropped, no error
    for (int i = 0; i < 17; i++) step(0, 0, 0, 32'hdead0000 + i, 1, 32'hc0de0000 + i, 0, 0, 0, 0, 0);
    chk("R11 full push no err", 32'(host_status[3]), 0);
    // R11: host write in read direction ignored
    step(0, 0, 1, 32'h1234, 0, 0, 0, 0, 0, 0, 0);
    // R2: drain in order; R7: read of empty
    for (int i = 0; i < 17; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 err set", 32'(host_status[3]), 1);
    // R9: clear together with new violation keeps bit set, then plain clear
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 4'h8);
    chk("R9 set wins", 32'(host_status[3]), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'h7);
    chk("R9 other bits no clear", 32'(host_status[3]), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'h8);
    chk("R9 cleared", 32'(host_status[3]), 0);
    // R10: partial fill then direction switch flushes
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 32'h55 + i, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h99, 1, 32'h77, 1, 0, 0, 0, 0);
    chk("R10 flushed", 32'(fill_level), 0);
    // R4/R6: threshold fields, write direction fill to full and beyond
    step(1, 0, 0, 0, 0, 0, 0, 1, 32'hfff80000 | (32'd9 << 14) | (32'd12 << 9) | 32'h1ff, 0, 0);
    for (int i = 0; i < 17; i++) step(1, 0, 1, 32'haa000000 + i, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 full write err", 32'(host_status[3]), 1);
    for (int i = 0; i < 17; i++) step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11 card pop empty", 32'(fill_level), 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'hf);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic d;
      logic [31:0] cf;
      d = (($urandom % 64) == 0) ? ~m_dir : m_dir;
      cf = $urandom;
      cf[13:9]  = 5'($urandom % 18);
      cf[18:14] = 5'($urandom % 18);
      step(d, 1'($urandom), 1'($urandom), $urandom, 1'($urandom), $urandom,
           1'($urandom), ($urandom % 16) == 0, cf, ($urandom % 8) == 0, 4'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule